// File: doc/BRIEF.md
# Synchronizable PWM Time-Base Counter

This block is the timing heart of one PWM channel. A counter of configurable width, 16 bits by default, steps once per prescaler tick. It can count up and wrap, count down and reload, or bounce between zero and the period for centre-aligned waveforms. The period value goes through a shadow stage so that software can change it without tearing a cycle. An optional bypass writes the live copy at once.

Several instances can be chained. A synchronization pulse, either from the sync input or from a software strobe, can load a phase value into the counter. It also restarts the prescaler and, in up-down mode, sets the direction of travel. Each instance drives a sync output from one of four selectable sources, which lets a master instance align the instances that follow it. Registered one-cycle strobes flag the counter landing on zero and on the period. Everything runs in one clock domain, and the prescaler only produces an enable pulse.

Top module: `pwm_timebase`

## Requirements
- R1: While reset is high and in the first cycle after it, count is 0, dir_up is 1, ev_zero, ev_period and sync_out are 0, and both period copies are 0.
- R2: With mode code 0 (up), each tick adds 1 to the counter. A tick while the count is at least the effective period sets it to 0. dir_up reads 1.
- R3: With mode code 1 (down), each tick subtracts 1. A tick at count 0 loads the effective period. dir_up reads 0.
- R4: With mode code 2 (up-down), a tick while rising with the count at least the period turns the direction down and steps the count to count-1, or keeps it at 0 if it is 0. A tick while falling at 0 turns the direction up and steps to 1, or stays at 0 when the period is 0.
- R5: With mode code 3 (hold), ticks leave the counter and direction unchanged.
- R6: When bypass is 0, a period write lands in the shadow copy. The active copy takes the shadow value on a tick that finds the counter at 0, and that same tick already uses the new value. When bypass is 1, a write updates the active copy at the next edge.
- R7: A sync event (sync_in or sync_sw high at an edge) always restarts the prescaler. With phase_en at 1 it also loads phase_val into the counter at that edge, whether or not a tick is due. With phase_en at 0 the count is left alone.
- R8: On a phase load in up-down mode, dir_up takes phase_dir_up. In up mode it reads 1 and in down mode it reads 0.
- R9: ev_zero (ev_period) is high for exactly the cycle after an edge at which the counter was updated, by a tick or a load, to 0 (to the active period).
- R10: sync_sel picks the sync_out source. Code 0 gives sync_in delayed one cycle. Code 1 gives the ev_zero pulse. Code 2 gives a one-cycle pulse after an update that makes the counter equal cmpb_val. Code 3 holds sync_out at 0.
- R11: The prescaler ticks in the cycle when its internal count reaches prescale, so a stable prescale value N gives one tick every N+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Count mode: 0 up, 1 down, 2 up-down, 3 hold |
| prescale | input | PRE_W | Tick divider; a tick every prescale+1 cycles |
| period_wr | input | 1 | Period write strobe |
| period_val | input | CNT_W | Period value written by period_wr |
| shadow_bypass | input | 1 | 1: writes go straight to the active period |
| phase_en | input | 1 | Enable phase load on sync |
| phase_val | input | CNT_W | Value loaded on sync |
| phase_dir_up | input | 1 | Direction after sync in up-down mode |
| cmpb_val | input | CNT_W | Compare value for sync_out source 2 |
| sync_sel | input | 2 | sync_out source select |
| sync_in | input | 1 | Hardware sync from the previous stage |
| sync_sw | input | 1 | Software sync strobe |
| count | output | CNT_W | Counter value |
| dir_up | output | 1 | 1 while counting up |
| ev_zero | output | 1 | Counter-reached-zero strobe |
| ev_period | output | 1 | Counter-reached-period strobe |
| sync_out | output | 1 | Sync to the next stage |

## Verification
On every cycle, the in-line properties check the up-mode wrap, the down-mode reload, the turn at the top in up-down mode, the freeze in hold mode and the phase load. They also check the shadow-to-active transfer, the spacing of prescaler ticks, the pairing of the zero strobe with a zero count, and the silence of sync_out when it is disabled. Some behaviour only the bench scenarios can show. This covers the exact cycle on which a new period takes effect, the combined result of direction, events and sync source over long runs with a random mix of periods, prescales, sync pulses and mode changes, and the bypass path.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
  typedef enum logic [1:0] {
    MODE_UP     = 2'd0,
    MODE_DOWN   = 2'd1,
    MODE_UPDOWN = 2'd2,
    MODE_HOLD   = 2'd3
  } cnt_mode_e;

  typedef enum logic [1:0] {
    SO_PASS = 2'd0,
    SO_ZERO = 2'd1,
    SO_CMPB = 2'd2,
    SO_NONE = 2'd3
  } so_sel_e;
endpackage

// File: rtl/tbc_prescaler.sv
module tbc_prescaler #(
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PRE_W-1:0] div,
  input  logic             restart,
  output logic             tick
);
  logic [PRE_W-1:0] pre_q;

  assign tick = (pre_q >= div);

  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else if (restart || tick) pre_q <= '0;
    else pre_q <= pre_q + 1'b1;
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
    (tick && !restart && div != '0) |=> (!tick || div == '0)); // R11
endmodule

// File: rtl/tbc_period_reg.sv
module tbc_period_reg #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CNT_W-1:0] wr_val,
  input  logic             bypass,
  input  logic             reload,
  output logic [CNT_W-1:0] eff_prd,
  output logic [CNT_W-1:0] act_next
);
  logic [CNT_W-1:0] shadow_q;
  logic [CNT_W-1:0] active_q;
  logic             take_shadow;

  assign take_shadow = reload && !bypass;
  assign eff_prd     = take_shadow ? shadow_q : active_q;

  always_comb begin
    act_next = active_q;
    if (wr && bypass) act_next = wr_val;
    else if (take_shadow) act_next = shadow_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (wr) shadow_q <= wr_val;
      active_q <= act_next;
    end
  end

  AST_SHADOW_XFER: assert property (@(posedge clk) disable iff (rst)
    (take_shadow && !wr) |=> (active_q == $past(shadow_q))); // R6
  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!reload && !bypass) |=> $stable(active_q)); // R6
endmodule

// File: rtl/tbc_counter.sv
module tbc_counter
  import tbc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  cnt_mode_e        mode,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] phase,
  input  logic             phase_dir_up,
  input  logic [CNT_W-1:0] eff_prd,
  input  logic [CNT_W-1:0] act_next,
  output logic [CNT_W-1:0] count_q,
  output logic             dir_q,
  output logic             ev_zero_q,
  output logic             ev_prd_q,
  output logic             upd,
  output logic [CNT_W-1:0] cnt_d
);
  logic dir_d;

  always_comb begin
    cnt_d = count_q;
    dir_d = dir_q;
    upd   = 1'b0;
    if (load) begin
      upd   = 1'b1;
      cnt_d = phase;
      case (mode)
        MODE_UP:     dir_d = 1'b1;
        MODE_DOWN:   dir_d = 1'b0;
        MODE_UPDOWN: dir_d = phase_dir_up;
        default:     dir_d = dir_q;
      endcase
    end else if (tick) begin
      case (mode)
        MODE_UP: begin
          upd   = 1'b1;
          dir_d = 1'b1;
          cnt_d = (count_q >= eff_prd) ? '0 : count_q + 1'b1;
        end
        MODE_DOWN: begin
          upd   = 1'b1;
          dir_d = 1'b0;
          cnt_d = (count_q == '0) ? eff_prd : count_q - 1'b1;
        end
        MODE_UPDOWN: begin
          upd = 1'b1;
          if (dir_q) begin
            if (count_q >= eff_prd) begin
              dir_d = 1'b0;
              cnt_d = (count_q == '0) ? '0 : count_q - 1'b1;
            end else begin
              cnt_d = count_q + 1'b1;
            end
          end else begin
            if (count_q == '0) begin
              dir_d = 1'b1;
              cnt_d = (eff_prd == '0) ? '0 : {{(CNT_W-1){1'b0}}, 1'b1};
            end else begin
              cnt_d = count_q - 1'b1;
            end
          end
        end
        default: begin
          upd = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q   <= '0;
      dir_q     <= 1'b1;
      ev_zero_q <= 1'b0;
      ev_prd_q  <= 1'b0;
    end else begin
      count_q   <= cnt_d;
      dir_q     <= dir_d;
      ev_zero_q <= upd && (cnt_d == '0);
      ev_prd_q  <= upd && (cnt_d == act_next);
    end
  end

  AST_UP_WRAP: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && mode == MODE_UP && count_q >= eff_prd) |=> (count_q == '0)); // R2
  AST_DOWN_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && mode == MODE_DOWN && count_q == '0) |=> (count_q == $past(eff_prd))); // R3
  AST_TURN_AT_TOP: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && mode == MODE_UPDOWN && dir_q && count_q >= eff_prd) |=> !dir_q); // R4
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_HOLD && !load) |=> $stable(count_q)); // R5
  AST_PHASE_LOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> (count_q == $past(phase))); // R7
  AST_ZERO_PULSE: assert property (@(posedge clk) disable iff (rst)
    ev_zero_q |-> (count_q == '0)); // R9
endmodule

// File: rtl/tbc_sync_out.sv
module tbc_sync_out
  import tbc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  so_sel_e          sel,
  input  logic             sync_in,
  input  logic             upd,
  input  logic [CNT_W-1:0] cnt_d,
  input  logic [CNT_W-1:0] cmpb,
  output logic             sync_out_q
);
  logic so_d;

  always_comb begin
    case (sel)
      SO_PASS: so_d = sync_in;
      SO_ZERO: so_d = upd && (cnt_d == '0);
      SO_CMPB: so_d = upd && (cnt_d == cmpb);
      default: so_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) sync_out_q <= 1'b0;
    else sync_out_q <= so_d;
  end

  AST_SYNC_SILENT: assert property (@(posedge clk) disable iff (rst)
    (sel == SO_NONE) |=> !sync_out_q); // R10
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import tbc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic [PRE_W-1:0] prescale,
  input  logic             period_wr,
  input  logic [CNT_W-1:0] period_val,
  input  logic             shadow_bypass,
  input  logic             phase_en,
  input  logic [CNT_W-1:0] phase_val,
  input  logic             phase_dir_up,
  input  logic [CNT_W-1:0] cmpb_val,
  input  logic [1:0]       sync_sel,
  input  logic             sync_in,
  input  logic             sync_sw,
  output logic [CNT_W-1:0] count,
  output logic             dir_up,
  output logic             ev_zero,
  output logic             ev_period,
  output logic             sync_out
);
  logic             sync_evt;
  logic             tick;
  logic             load;
  logic             reload;
  logic             upd;
  logic [CNT_W-1:0] eff_prd;
  logic [CNT_W-1:0] act_next;
  logic [CNT_W-1:0] cnt_d;

  assign sync_evt = sync_in || sync_sw;
  assign load     = sync_evt && phase_en;
  assign reload   = tick && (count == '0);

  tbc_prescaler #(.PRE_W(PRE_W)) i_pre (
    .clk     (clk),
    .rst     (rst),
    .div     (prescale),
    .restart (sync_evt),
    .tick    (tick)
  );

  tbc_period_reg #(.CNT_W(CNT_W)) i_prd (
    .clk      (clk),
    .rst      (rst),
    .wr       (period_wr),
    .wr_val   (period_val),
    .bypass   (shadow_bypass),
    .reload   (reload),
    .eff_prd  (eff_prd),
    .act_next (act_next)
  );

  tbc_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk          (clk),
    .rst          (rst),
    .mode         (cnt_mode_e'(mode)),
    .tick         (tick),
    .load         (load),
    .phase        (phase_val),
    .phase_dir_up (phase_dir_up),
    .eff_prd      (eff_prd),
    .act_next     (act_next),
    .count_q      (count),
    .dir_q        (dir_up),
    .ev_zero_q    (ev_zero),
    .ev_prd_q     (ev_period),
    .upd          (upd),
    .cnt_d        (cnt_d)
  );

  tbc_sync_out #(.CNT_W(CNT_W)) i_so (
    .clk        (clk),
    .rst        (rst),
    .sel        (so_sel_e'(sync_sel)),
    .sync_in    (sync_in),
    .upd        (upd),
    .cnt_d      (cnt_d),
    .cmpb       (cmpb_val),
    .sync_out_q (sync_out)
  );
endmodule

// File: tb/test_pwm_timebase.sv
module test_pwm_timebase;
  localparam int W = 16;
  localparam int P = 4;

  logic         clk = 1'b0;
  logic         rst;
  logic [1:0]   mode;
  logic [P-1:0] prescale;
  logic         period_wr;
  logic [W-1:0] period_val;
  logic         shadow_bypass;
  logic         phase_en;
  logic [W-1:0] phase_val;
  logic         phase_dir_up;
  logic [W-1:0] cmpb_val;
  logic [1:0]   sync_sel;
  logic         sync_in;
  logic         sync_sw;
  logic [W-1:0] count;
  logic         dir_up, ev_zero, ev_period, sync_out;

  always #5 clk = ~clk;

  pwm_timebase #(.CNT_W(W), .PRE_W(P)) i_pwm_timebase (
    .clk(clk), .rst(rst), .mode(mode), .prescale(prescale),
    .period_wr(period_wr), .period_val(period_val), .shadow_bypass(shadow_bypass),
    .phase_en(phase_en), .phase_val(phase_val), .phase_dir_up(phase_dir_up),
    .cmpb_val(cmpb_val), .sync_sel(sync_sel), .sync_in(sync_in), .sync_sw(sync_sw),
    .count(count), .dir_up(dir_up), .ev_zero(ev_zero), .ev_period(ev_period),
    .sync_out(sync_out)
  );

  int    checks = 0;
  int    errors = 0;
  string cur_tag = "";
  bit    last_load = 1'b0;

  // reference state
  logic [W-1:0] m_cnt, m_sh, m_act;
  logic [P-1:0] m_pre;
  logic         m_dir, m_ez, m_ep, m_so;

  always @(posedge clk) begin : model
    logic         sev, tk, ld, upd, nd;
    logic [W-1:0] eff, nc, na;
    if (rst) begin
      m_cnt = '0; m_sh = '0; m_act = '0; m_pre = '0;
      m_dir = 1'b1; m_ez = 1'b0; m_ep = 1'b0; m_so = 1'b0; last_load = 1'b0;
    end else begin
      sev = sync_in | sync_sw;
      tk  = (m_pre >= prescale);
      ld  = sev & phase_en;
      eff = (!shadow_bypass && tk && m_cnt == 0) ? m_sh : m_act;
      na  = m_act;
      if (period_wr && shadow_bypass) na = period_val;
      else if (!shadow_bypass && tk && m_cnt == 0) na = m_sh;
      nc = m_cnt; nd = m_dir; upd = 1'b0;
      if (ld) begin
        upd = 1'b1; nc = phase_val;
        if (mode == 2'd0) nd = 1'b1;
        else if (mode == 2'd1) nd = 1'b0;
        else if (mode == 2'd2) nd = phase_dir_up;
      end else if (tk && mode != 2'd3) begin
        upd = 1'b1;
        if (mode == 2'd0) begin nd = 1'b1; nc = (m_cnt >= eff) ? 16'd0 : m_cnt + 16'd1; end
        else if (mode == 2'd1) begin nd = 1'b0; nc = (m_cnt == 0) ? eff : m_cnt - 16'd1; end
        else if (m_dir) begin
          if (m_cnt >= eff) begin nd = 1'b0; nc = (m_cnt == 0) ? 16'd0 : m_cnt - 16'd1; end
          else nc = m_cnt + 16'd1;
        end else begin
          if (m_cnt == 0) begin nd = 1'b1; nc = (eff == 0) ? 16'd0 : 16'd1; end
          else nc = m_cnt - 16'd1;
        end
      end
      m_ez = upd && nc == 0;
      m_ep = upd && nc == na;
      case (sync_sel)
        2'd0: m_so = sync_in;
        2'd1: m_so = m_ez;
        2'd2: m_so = upd && nc == cmpb_val;
        default: m_so = 1'b0;
      endcase
      m_pre = (sev || tk) ? '0 : m_pre + 1'b1;
      if (period_wr) m_sh = period_val;
      m_act = na; m_cnt = nc; m_dir = nd; last_load = ld;
    end
  end

  task automatic chk(input string tag, input string name, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, name, act, exp);
    end
  endtask

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic cyc();
    string tc, td;
    @(negedge clk);
    tc = (cur_tag != "") ? cur_tag : (last_load ? "R7" : mode_tag(mode));
    td = (cur_tag != "") ? cur_tag : (last_load ? "R8" : mode_tag(mode));
    chk(tc, "count", count, m_cnt);
    chk(td, "dir_up", {15'd0, dir_up}, {15'd0, m_dir});
    chk((cur_tag != "") ? cur_tag : "R9", "ev_zero", {15'd0, ev_zero}, {15'd0, m_ez});
    chk((cur_tag != "") ? cur_tag : "R9", "ev_period", {15'd0, ev_period}, {15'd0, m_ep});
    chk((cur_tag != "") ? cur_tag : "R10", "sync_out", {15'd0, sync_out}, {15'd0, m_so});
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr_period(input logic [W-1:0] v);
    period_wr = 1'b1; period_val = v; cyc(); period_wr = 1'b0;
  endtask

  task automatic pulse_sw();
    sync_sw = 1'b1; cyc(); sync_sw = 1'b0;
  endtask

  task automatic pulse_in();
    sync_in = 1'b1; cyc(); sync_in = 1'b0;
  endtask

  initial begin : watchdog
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    rst = 1'b1; mode = 2'd0; prescale = '0; period_wr = 1'b0; period_val = '0;
    shadow_bypass = 1'b0; phase_en = 1'b0; phase_val = '0; phase_dir_up = 1'b0;
    cmpb_val = '0; sync_sel = 2'd3; sync_in = 1'b0; sync_sw = 1'b0;
    repeat (3) @(negedge clk);
    // R1 literal reset values
    chk("R1", "count", count, 16'd0);
    chk("R1", "dir_up", {15'd0, dir_up}, 16'd1);
    chk("R1", "ev_zero", {15'd0, ev_zero}, 16'd0);
    chk("R1", "ev_period", {15'd0, ev_period}, 16'd0);
    chk("R1", "sync_out", {15'd0, sync_out}, 16'd0);
    rst = 1'b0;
    cur_tag = "R1"; cyc(); cur_tag = "";

    // up mode with bypass write of period 4
    shadow_bypass = 1'b1; wr_period(16'd4); shadow_bypass = 1'b0;
    run(6);
    chk("R2", "count after wrap", count, 16'd0 + m_cnt);
    run(10);
    // shadow write: active must follow only at zero
    cur_tag = "R6"; wr_period(16'd9); run(25); shadow_bypass = 1'b1; wr_period(16'd3);
    shadow_bypass = 1'b0; run(10); cur_tag = "";
    mode = 2'd1; run(20);
    mode = 2'd2; wr_period(16'd6); run(40);
    mode = 2'd3; run(8);
    // prescaler
    cur_tag = "R11"; mode = 2'd0; prescale = 4'd3; run(40); prescale = 4'd0; cur_tag = "";
    // sync phase loads
    cur_tag = "R7"; phase_en = 1'b1; phase_val = 16'd2; pulse_sw(); run(4);
    phase_val = 16'd7; pulse_in(); run(4);
    phase_en = 1'b0; pulse_sw(); run(4); cur_tag = "";
    cur_tag = "R8"; mode = 2'd2; phase_en = 1'b1; phase_val = 16'd3;
    phase_dir_up = 1'b0; pulse_in(); run(5);
    phase_dir_up = 1'b1; pulse_sw(); run(5); phase_en = 1'b0; cur_tag = "";
    // sync output sources
    cur_tag = "R10"; cmpb_val = 16'd2;
    for (int s = 0; s < 4; s++) begin
      sync_sel = s[1:0]; run(3); pulse_in(); run(15);
    end
    cur_tag = "";

    // random segments
    for (int seg = 0; seg < 24; seg++) begin
      mode          = 2'($urandom_range(0, 3));
      prescale      = 4'($urandom_range(0, 3));
      shadow_bypass = 1'($urandom_range(0, 1));
      phase_en      = 1'($urandom_range(0, 1));
      phase_dir_up  = 1'($urandom_range(0, 1));
      sync_sel      = 2'($urandom_range(0, 3));
      cmpb_val      = 16'($urandom_range(0, 12));
      for (int c = 0; c < 250; c++) begin
        period_wr  = ($urandom_range(0, 19) == 0);
        period_val = 16'($urandom_range(0, 15));
        phase_val  = 16'($urandom_range(0, 15));
        sync_in    = ($urandom_range(0, 39) == 0);
        sync_sw    = ($urandom_range(0, 59) == 0);
        cyc();
      end
      period_wr = 1'b0; sync_in = 1'b0; sync_sw = 1'b0;
    end
    cyc();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule